// File: doc/BRIEF.md
# Block-Cipher Register and FIFO Front-End

This block sits between a 32-bit register bus and a block-cipher core. Software loads a 256-bit key through eight write-only key words, selects a key length and an operation type in a control register, and pushes a 128-bit block as four 32-bit words into an input FIFO register. The fourth word launches the core with no further command. A START bit in the control register can also launch the core on whatever the block buffer currently holds. The core's 128-bit answer comes back through an output FIFO register, one word per read.

Encrypt and decrypt operations both save the key they used, and its length, as an internal decryption key. A third operation type decrypts with that saved key and ignores whatever the key words hold now. A single interrupt flag reports completion and drives `irq` when it is enabled. The cipher rounds themselves live in the attached core, which the front-end drives through a start/done handshake.

Top module: `cipher_fe`

## Requirements
- R1: Only word-aligned offsets decode. The map is: control 0x000, status 0x004, interrupt flag 0x008, interrupt enable 0x00C, FIFO 0x010, and key words 0x020 to 0x03C. A write to any other offset, including an offset with a nonzero low address pair, has no effect. A read of any other offset returns zero, and the key words also read as zero.
- R2: Status is always current with the counts. Bit 0 is input-full (four words held), bit 1 is input-empty, bit 2 is output-full (four result words held) and bit 3 is output-empty.
- R3: Successive FIFO writes fill the block from the highest-order word (bits 127:96) down to the lowest. When the fourth word is written, the input count returns to zero and the core is launched in the same cycle.
- R4: A FIFO read with result words held returns bits [31:0] first, then [63:32], [95:64] and [127:96]. Each such read lowers the count by one and clears the DONE flag. A FIFO read with no result held returns zero and changes nothing.
- R5: In a control write, bit 3 empties the result count and bit 2 empties the input count. Neither bit is stored. Bit 1 (START), which is also not stored, launches the core on the current block buffer without clearing the input count. It uses the type and length fields of that same write.
- R6: Control bit 0 (enable), once written to 1, reads as 1 until reset, whatever is written later.
- R7: The length field, control bits 7:6, works as follows. Value 0 passes only key bits 127:0 to the core and reports length code 0. Value 1 passes bits 191:0 and reports code 1. Values 2 and 3 pass all 256 bits and report code 2. Unused key bits are driven as zero.
- R8: The type field, control bits 9:8, works as follows. Value 0 encrypts and value 1 decrypts, and both save the selected key and length code. Values 2 and 3 decrypt with the saved key and length, regardless of the current key words and length field.
- R9: Key word offset 0x020 + 4*i holds key bits [32*(7-i)+31 : 32*(7-i)], so the lowest address is the highest-order word.
- R10: When the core signals done, the four result words become readable, the count becomes four and the DONE flag (interrupt-flag bit 0) sets. `irq` is high exactly when DONE and interrupt-enable bit 0 are both set.
- R11: While an operation is in flight, FIFO writes and START are ignored.
- R12: Reset clears control, interrupt flag, interrupt enable, both counts, block, key, result and saved key. Status then reads 0xA.
- R13: `core_start` is a one-cycle pulse issued in the cycle after a launch. The block, key, length code and decrypt select presented with it stay stable until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (FIFO reads pop at the clock edge) |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| irq | output | 1 | Interrupt request |
| core_start | output | 1 | Launch pulse to the cipher core |
| core_decrypt | output | 1 | 1 selects decryption |
| core_klen | output | 2 | Key length code: 0, 1 or 2 for 128, 192 or 256 bits |
| core_key | output | 256 | Selected key, zero above the chosen length |
| core_block | output | 128 | Block to process |
| core_done | input | 1 | Core completion pulse |
| core_result | input | 128 | Core output block, valid with core_done |

## Verification
The hardest case to reach is the saved-key path. It needs an operation that saves a key, then new key words and a different length field, then a reuse-type launch. The result must follow the old key and length rather than anything visible in the registers. The stimulus runs a 256-bit encrypt, rewrites every key word, and selects length 0 with type 2. Its expected value is computed from the bench's record of the earlier key. In-flight input is reached by writing a fifth word and a START straight after the fourth word, inside the core stub's latency.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  localparam int ADDR_W    = 12;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 4;
  localparam int KEY_WORDS = 8;
  localparam int BLK_W     = WORD_W * BLK_WORDS;
  localparam int KEY_W     = WORD_W * KEY_WORDS;
  localparam int CNT_W     = $clog2(BLK_WORDS + 1);
  localparam int KIDX_W    = $clog2(KEY_WORDS);

  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_IFLG = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_FIFO = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 12'h020;

  localparam int CB_EN     = 0;
  localparam int CB_START  = 1;
  localparam int CB_IFLUSH = 2;
  localparam int CB_OFLUSH = 3;
  localparam int CB_LEN    = 6;
  localparam int CB_TYPE   = 8;

  typedef enum logic [1:0] {
    KLEN_128 = 2'd0,
    KLEN_192 = 2'd1,
    KLEN_256 = 2'd2
  } klen_e;

  function automatic klen_e klen_norm(input logic [1:0] f);
    case (f)
      2'd0:    return KLEN_128;
      2'd1:    return KLEN_192;
      default: return KLEN_256;
    endcase
  endfunction

  // Keep only the low-order bits that the chosen length uses.
  function automatic logic [KEY_W-1:0] key_pick(input logic [KEY_W-1:0] k, input klen_e l);
    logic [KEY_W-1:0] m;
    case (l)
      KLEN_128: m = {{(KEY_W-128){1'b0}}, {128{1'b1}}};
      KLEN_192: m = {{(KEY_W-192){1'b0}}, {192{1'b1}}};
      default:  m = {KEY_W{1'b1}};
    endcase
    return k & m;
  endfunction

  function automatic logic [3:0] status_pack(input logic [CNT_W-1:0] dc, input logic [CNT_W-1:0] rc);
    return {rc == '0, rc == CNT_W'(BLK_WORDS), dc == '0, dc == CNT_W'(BLK_WORDS)};
  endfunction
endpackage

// File: rtl/cfe_infifo.sv
module cfe_infifo #(
  parameter int WORDS = 4,
  parameter int W     = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic [W-1:0]                   push_word,
  output logic [$clog2(WORDS+1)-1:0]     count,
  output logic [WORDS*W-1:0]             block_nxt,
  output logic                           last_push
);
  localparam int CW = $clog2(WORDS + 1);
  logic [WORDS*W-1:0] block_q;

  // Word position counted from the top of the block.
  always_comb begin
    block_nxt = block_q;
    if (push) block_nxt[(WORDS-1-int'(count))*W +: W] = push_word;
  end

  assign last_push = push && (count == CW'(WORDS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      block_q <= '0;
    end else begin
      block_q <= block_nxt;
      if (flush)          count <= '0;
      else if (last_push) count <= '0;
      else if (push)      count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/cfe_outfifo.sv
module cfe_outfifo #(
  parameter int WORDS = 4,
  parameter int W     = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic [WORDS*W-1:0]             load_blk,
  input  logic                           flush,
  input  logic                           pop,
  output logic [$clog2(WORDS+1)-1:0]     count,
  output logic [W-1:0]                   head,
  output logic                           pop_ok
);
  localparam int CW = $clog2(WORDS + 1);
  logic [WORDS*W-1:0] blk_q;

  assign pop_ok = pop && (count != '0) && !load;
  // With c words held the next one out sits at bit (WORDS-c)*W.
  assign head   = (count == '0) ? '0 : blk_q[(WORDS-int'(count))*W +: W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      blk_q <= '0;
    end else if (load) begin
      count <= CW'(WORDS);
      blk_q <= load_blk;
    end else if (flush) begin
      count <= '0;
    end else if (pop_ok) begin
      count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/cfe_keybank.sv
module cfe_keybank
  import cfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [KIDX_W-1:0] widx,
  input  logic [WORD_W-1:0] wword,
  input  logic              latch,
  input  klen_e             sel_len,
  output logic [KEY_W-1:0]  live_key,
  output logic [KEY_W-1:0]  saved_key,
  output klen_e             saved_len
);
  logic [KEY_W-1:0] store_q;

  assign live_key = key_pick(store_q, sel_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q   <= '0;
      saved_key <= '0;
      saved_len <= KLEN_128;
    end else begin
      // Lowest word index lands in the highest-order key word.
      if (wr) store_q[(KEY_WORDS-1-int'(widx))*WORD_W +: WORD_W] <= wword;
      if (latch) begin
        saved_key <= live_key;
        saved_len <= sel_len;
      end
    end
  end
endmodule

// File: rtl/cipher_fe.sv
module cipher_fe
  import cfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq,
  output logic              core_start,
  output logic              core_decrypt,
  output logic [1:0]        core_klen,
  output logic [KEY_W-1:0]  core_key,
  output logic [BLK_W-1:0]  core_block,
  input  logic              core_done,
  input  logic [BLK_W-1:0]  core_result
);
  localparam logic [WORD_W-1:0] SELFCLR = WORD_W'((1 << CB_START) | (1 << CB_IFLUSH) | (1 << CB_OFLUSH));
  localparam logic [WORD_W-1:0] EN_MASK = WORD_W'(1 << CB_EN);

  logic [WORD_W-1:0] ctrl_q;
  logic              ien_q, iflg_q, busy_q;
  klen_e             klen_q;

  logic aligned, hit_ctrl, hit_stat, hit_iflg, hit_ien, hit_fifo, hit_key;
  logic [KIDX_W-1:0] widx;
  assign aligned  = bus_addr[1:0] == 2'b00;
  assign hit_ctrl = aligned && bus_addr == OFS_CTRL;
  assign hit_stat = aligned && bus_addr == OFS_STAT;
  assign hit_iflg = aligned && bus_addr == OFS_IFLG;
  assign hit_ien  = aligned && bus_addr == OFS_IEN;
  assign hit_fifo = aligned && bus_addr == OFS_FIFO;
  assign hit_key  = aligned && bus_addr >= OFS_KEY && bus_addr < OFS_KEY + ADDR_W'(4*KEY_WORDS);
  assign widx     = KIDX_W'((bus_addr - OFS_KEY) >> 2);

  logic wr_ctrl, in_flush, out_flush, cmd_start, fifo_push, fifo_pop;
  logic launch_evt, done_evt, reuse, latch_key;
  logic [1:0] op_field, len_field;
  klen_e sel_len;
  assign wr_ctrl   = bus_wr && hit_ctrl;
  assign in_flush  = wr_ctrl && bus_wdata[CB_IFLUSH];
  assign out_flush = wr_ctrl && bus_wdata[CB_OFLUSH];
  assign cmd_start = wr_ctrl && bus_wdata[CB_START] && !busy_q;
  assign fifo_push = bus_wr && hit_fifo && !busy_q;
  assign fifo_pop  = bus_rd && hit_fifo;
  assign done_evt  = core_done && busy_q;

  logic [CNT_W-1:0]  dcnt, rcnt;
  logic [BLK_W-1:0]  block_nxt;
  logic              last_push, pop_ok;
  logic [WORD_W-1:0] head;
  logic [KEY_W-1:0]  live_key, saved_key;
  klen_e             saved_len;

  assign launch_evt = cmd_start || last_push;
  assign op_field   = cmd_start ? bus_wdata[CB_TYPE +: 2] : ctrl_q[CB_TYPE +: 2];
  assign len_field  = cmd_start ? bus_wdata[CB_LEN +: 2]  : ctrl_q[CB_LEN +: 2];
  assign reuse      = op_field[1];
  assign sel_len    = klen_norm(len_field);
  assign latch_key  = launch_evt && !reuse;

  cfe_infifo #(.WORDS(BLK_WORDS), .W(WORD_W)) u_in (
    .clk(clk), .rst_n(rst_n), .flush(in_flush), .push(fifo_push),
    .push_word(bus_wdata), .count(dcnt), .block_nxt(block_nxt), .last_push(last_push)
  );

  cfe_outfifo #(.WORDS(BLK_WORDS), .W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(done_evt), .load_blk(core_result),
    .flush(out_flush), .pop(fifo_pop), .count(rcnt), .head(head), .pop_ok(pop_ok)
  );

  cfe_keybank u_key (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr && hit_key), .widx(widx), .wword(bus_wdata),
    .latch(latch_key), .sel_len(sel_len), .live_key(live_key),
    .saved_key(saved_key), .saved_len(saved_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      ien_q        <= 1'b0;
      iflg_q       <= 1'b0;
      busy_q       <= 1'b0;
      core_start   <= 1'b0;
      core_decrypt <= 1'b0;
      klen_q       <= KLEN_128;
      core_key     <= '0;
      core_block   <= '0;
    end else begin
      if (wr_ctrl)         ctrl_q <= (bus_wdata & ~SELFCLR) | (ctrl_q & EN_MASK);
      if (bus_wr && hit_ien) ien_q <= bus_wdata[0];
      core_start <= launch_evt;
      if (launch_evt) begin
        busy_q       <= 1'b1;
        core_decrypt <= op_field != 2'd0;
        klen_q       <= reuse ? saved_len : sel_len;
        core_key     <= reuse ? saved_key : live_key;
        core_block   <= block_nxt;
      end else if (done_evt) begin
        busy_q <= 1'b0;
      end
      if (done_evt)    iflg_q <= 1'b1;
      else if (pop_ok) iflg_q <= 1'b0;
    end
  end

  assign core_klen = klen_q;
  assign irq       = iflg_q && ien_q;

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = ctrl_q;
    else if (hit_stat) bus_rdata = WORD_W'(status_pack(dcnt, rcnt));
    else if (hit_iflg) bus_rdata = WORD_W'(iflg_q);
    else if (hit_ien)  bus_rdata = WORD_W'(ien_q);
    else if (hit_fifo) bus_rdata = head;
  end
endmodule

// File: rtl/cipher_fe_chk.sv
module cipher_fe_chk
  import cfe_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             core_start,
  input logic             core_done,
  input logic             busy_q,
  input logic [CNT_W-1:0] rcnt,
  input logic [CNT_W-1:0] dcnt,
  input logic             done_evt,
  input logic             fifo_push,
  input logic             pop_ok,
  input logic             ctrl_en,
  input logic             iflg_q
);
  assert_start_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  assert_start_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> busy_q);
  assert_fourth_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push && dcnt == CNT_W'(BLK_WORDS-1)) |=> (dcnt == '0 && core_start));
  assert_done_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (rcnt == CNT_W'(BLK_WORDS) && iflg_q));
  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (rcnt == $past(rcnt) - CNT_W'(1) && !iflg_q));
  assert_en_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |=> ctrl_en);
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !core_done) |=> busy_q);
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rcnt <= CNT_W'(BLK_WORDS) && dcnt < CNT_W'(BLK_WORDS)));
endmodule

bind cipher_fe cipher_fe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_start(core_start), .core_done(core_done),
  .busy_q(busy_q), .rcnt(rcnt), .dcnt(dcnt), .done_evt(done_evt),
  .fifo_push(fifo_push), .pop_ok(pop_ok), .ctrl_en(ctrl_q[0]), .iflg_q(iflg_q)
);

// File: tb/cipher_fe_tb.sv
module cipher_fe_tb;
  localparam logic [11:0] A_CTRL = 12'h000, A_STAT = 12'h004, A_IFLG = 12'h008,
                          A_IEN = 12'h00C, A_FIFO = 12'h010, A_KEY = 12'h020;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, core_start, core_decrypt, core_done;
  logic [1:0] core_klen;
  logic [255:0] core_key;
  logic [127:0] core_block, core_result;

  always #5 clk = ~clk;

  cipher_fe u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .core_start(core_start),
    .core_decrypt(core_decrypt), .core_klen(core_klen), .core_key(core_key),
    .core_block(core_block), .core_done(core_done), .core_result(core_result)
  );

  function automatic logic [127:0] mdl(input logic [127:0] b, input logic [255:0] k,
                                       input logic dec, input logic [1:0] kl);
    return b ^ k[127:0] ^ k[255:128] ^ (dec ? {128{1'b1}} : 128'd0) ^ {126'd0, kl};
  endfunction

  // Reversible stub core, three cycles of latency.
  int stub_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      stub_cnt <= 0; core_done <= 1'b0; core_result <= '0;
    end else if (core_start) begin
      stub_cnt <= 3; core_done <= 1'b0;
    end else if (stub_cnt > 1) begin
      stub_cnt <= stub_cnt - 1; core_done <= 1'b0;
    end else if (stub_cnt == 1) begin
      stub_cnt <= 0; core_done <= 1'b1;
      core_result <= mdl(core_block, core_key, core_decrypt, core_klen);
    end else begin
      core_done <= 1'b0;
    end
  end

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard: expected FIFO words, compared by the monitor as they are read.
  logic [31:0] exp_q[$];
  string       exp_tag[$];
  always @(negedge clk) begin
    if (bus_rd && bus_addr == A_FIFO && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = exp_tag.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  task automatic push_res(input logic [127:0] r, input int nwords, input string tag);
    for (int i = 0; i < nwords; i++) begin
      exp_q.push_back(r[32*i +: 32]);
      exp_tag.push_back(tag);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    bit ok;
    ok = 0;
    for (int i = 0; i < 40 && !ok; i++) begin
      rd(A_STAT, s);
      if (s[2]) ok = 1;
    end
    chk(req, {31'd0, ok}, 32'd1);
  endtask

  logic [31:0] kw[8];
  function automatic logic [255:0] kfull();
    return {kw[0], kw[1], kw[2], kw[3], kw[4], kw[5], kw[6], kw[7]};
  endfunction
  function automatic logic [255:0] kpick(input logic [255:0] f, input int kl);
    if (kl == 0) return {128'd0, f[127:0]};
    if (kl == 1) return {64'd0, f[191:0]};
    return f;
  endfunction

  task automatic load_keys(input logic [31:0] seed);
    for (int i = 0; i < 8; i++) begin
      kw[i] = seed ^ (32'h0101_0101 * (i + 1));
      wr(A_KEY + 12'(4*i), kw[i]);
    end
  endtask

  task automatic run_block(input logic [127:0] b, input logic [127:0] expr, input string tag);
    for (int i = 0; i < 4; i++) wr(A_FIFO, b[127-32*i -: 32]);
    wait_done(tag);
    push_res(expr, 4, tag);
    for (int i = 0; i < 4; i++) begin logic [31:0] d; rd(A_FIFO, d); end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [255:0] k_old;
    logic [127:0] buf_m, blk;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R12 reset state
    rd(A_CTRL, d); chk("R12 ctrl", d, 32'h0);
    rd(A_STAT, d); chk("R12 status", d, 32'hA);
    rd(A_IFLG, d); chk("R12 iflag", d, 32'h0);
    rd(A_IEN, d);  chk("R12 ienable", d, 32'h0);
    chk("R12 irq", {31'd0, irq}, 32'h0);
    rd(A_FIFO, d); chk("R4 empty read", d, 32'h0);
    rd(A_KEY, d);  chk("R1 key reads zero", d, 32'h0);

    // R3 R7 R9: 128-bit encrypt, auto launch on fourth word
    load_keys(32'hA5C3_0F11);
    wr(A_CTRL, 32'h1);
    blk = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
    for (int i = 0; i < 3; i++) wr(A_FIFO, blk[127-32*i -: 32]);
    rd(A_STAT, d); chk("R2 partial input", d, 32'h8);
    wr(A_FIFO, blk[31:0]);
    wait_done("R3 auto launch");
    rd(A_IFLG, d); chk("R10 done flag", d, 32'h1);
    chk("R10 irq masked", {31'd0, irq}, 32'h0);
    wr(A_IEN, 32'h1);
    chk("R10 irq enabled", {31'd0, irq}, 32'h1);
    rd(A_STAT, d); chk("R2 output full", d, 32'h6);
    push_res(mdl(blk, kpick(kfull(), 0), 1'b0, 2'd0), 4, "R7 R9 R4 encrypt128");
    rd(A_FIFO, d);
    rd(A_IFLG, d); chk("R4 read clears done", d, 32'h0);
    chk("R4 irq drops", {31'd0, irq}, 32'h0);
    for (int i = 0; i < 3; i++) rd(A_FIFO, d);
    rd(A_STAT, d); chk("R2 drained", d, 32'hA);
    rd(A_FIFO, d); chk("R4 empty read after drain", d, 32'h0);

    // R6 enable sticky; R7 192-bit decrypt
    wr(A_CTRL, 32'h0000_0140);
    rd(A_CTRL, d); chk("R6 enable sticky", d, 32'h0000_0141);
    blk = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F0E1_D2C3;
    run_block(blk, mdl(blk, kpick(kfull(), 1), 1'b1, 2'd1), "R7 decrypt192");

    // R7 field value 3 -> 256 bits, encrypt
    wr(A_CTRL, 32'h0000_00C1);
    blk = 128'h1357_9BDF_2468_ACE0_1122_3344_5566_7788;
    run_block(blk, mdl(blk, kfull(), 1'b0, 2'd2), "R7 encrypt256");
    k_old = kfull();

    // R8 reuse saved key after rewriting keys and length
    load_keys(32'h3C3C_9999);
    wr(A_CTRL, 32'h0000_0201);
    blk = 128'h0F0F_0F0F_1234_5678_9ABC_DEF0_5555_AAAA;
    run_block(blk, mdl(blk, k_old, 1'b1, 2'd2), "R8 saved key reuse");

    // R11 writes and START ignored while busy
    wr(A_CTRL, 32'h1);
    buf_m = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    for (int i = 0; i < 4; i++) wr(A_FIFO, buf_m[127-32*i -: 32]);
    wr(A_FIFO, 32'hBAD0_BAD0);
    wr(A_CTRL, 32'h3);
    wait_done("R11 busy run");
    rd(A_STAT, d); chk("R11 fifo write ignored", d, 32'h6);
    push_res(mdl(buf_m, kpick(kfull(), 0), 1'b0, 2'd0), 4, "R11 result");
    for (int i = 0; i < 4; i++) rd(A_FIFO, d);
    repeat (10) @(posedge clk); #1;
    rd(A_STAT, d); chk("R11 start ignored", d, 32'hA);

    // R5 flush bits and START on a partial buffer
    wr(A_FIFO, 32'hF000_0000); wr(A_FIFO, 32'hF111_1111);
    buf_m[127:64] = {32'hF000_0000, 32'hF111_1111};
    rd(A_STAT, d); chk("R5 before flush", d, 32'h8);
    wr(A_CTRL, 32'h5);
    rd(A_STAT, d); chk("R5 input flush", d, 32'hA);
    rd(A_CTRL, d); chk("R5 flush not stored", d, 32'h1);
    wr(A_FIFO, 32'h6060_6060);
    buf_m[127:96] = 32'h6060_6060;
    wr(A_CTRL, 32'h3);
    wait_done("R5 start launch");
    rd(A_STAT, d); chk("R5 start keeps input count", d, 32'h4);
    push_res(mdl(buf_m, kpick(kfull(), 0), 1'b0, 2'd0), 2, "R5 start on buffer");
    rd(A_FIFO, d); rd(A_FIFO, d);
    wr(A_CTRL, 32'hD);
    rd(A_STAT, d); chk("R5 both flushed", d, 32'hA);
    rd(A_FIFO, d); chk("R5 flushed read zero", d, 32'h0);

    // R1 unmapped and misaligned accesses
    wr(12'h100, 32'hFFFF_FFFF);
    wr(A_IEN + 12'h1, 32'h0);
    rd(A_IEN, d);  chk("R1 misaligned write ignored", d, 32'h1);
    rd(12'h100, d); chk("R1 unmapped read", d, 32'h0);
    rd(A_CTRL + 12'h2, d); chk("R1 misaligned read", d, 32'h0);

    // R12 reset clears enable and interrupt enable
    #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    rd(A_CTRL, d); chk("R12 ctrl after reset", d, 32'h0);
    rd(A_IEN, d);  chk("R12 ien after reset", d, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule